// File: doc/BRIEF.md
# Far-End Alarm Code Receiver

This block sits behind a DS3 receive framer and takes the far-end alarm and control (FEAC) channel as a serial bit stream, one bit for each cycle in which the bit strobe is high. It finds 16-bit FEAC messages in that stream on its own and takes the 6-bit code out of each one. The far end sends every message ten times in a row, so the block keeps the ten most recent codes in a sliding window and votes on them.

A code is declared valid once it fills at least eight of the ten window slots. It is written into a code register, and a validation interrupt status bit is raised. A validated code is withdrawn once three or more entries in the window differ from it. The withdrawal clears the valid flag and raises a removal interrupt status bit, and the code register keeps its old contents. Software reaches the block through a small register port with two addresses. The two status bits clear when they are read. Each status bit has its own enable bit, and a level interrupt output is high while an enabled status bit is set.

Top module: `feac_rx`

## Requirements
- R1: A message is recognised only when 16 consecutive strobed bits, first-received bit in position 0, have 0 in bit 0, 0 in bit 7 and 1 in bits 15:8. The code is bits 6:1, so the first received code bit is its least significant bit. Any other bit pattern adds nothing to the window.
- R2: When a newly received code equals at least 8 of the filled window entries and no code is valid, that code is written to the code register. The valid flag (bit 4 at address 1) and the validation status (bit 0 at address 1) are both set.
- R3: While no code is valid and fewer than 8 filled entries match the newest code, the valid flag and the validation status stay clear.
- R4: While a code is valid, a new entry that leaves 3 or more filled entries different from it sets the removal status (bit 2 at address 1) and clears the valid flag. The code register keeps its value.
- R5: While a code is valid, no removal occurs as long as at most 2 filled entries differ from it.
- R6: After a removal, a new validation, possibly of another code, happens as soon as the rule of R2 holds again.
- R7: At address 1, bits 3 (removal enable) and 1 (validation enable) are read/write. Bits 0, 2 and 4 are not affected by writes, bits 7:5 read 0, and a read of address 1 clears bits 0 and 2.
- R8: Output irq is high while (bit 0 and bit 1) or (bit 2 and bit 3) of address 1 are both set. It follows the register one cycle later.
- R9: When a status bit is set in the same cycle as a read of address 1, the bit ends up set. The data returned by that read shows the value from before the event.
- R10: After reset, the window is empty, all status, enable and valid bits are 0, the code register is 0, and irq is 0.
- R11: A read of address 0 returns the code in bits 6:1 with bits 7 and 0 at 0. Read data is registered and appears the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_bit_en | input | 1 | Strobe, fe_bit is taken in this cycle |
| fe_bit | input | 1 | Serial alarm channel bit |
| reg_addr | input | 1 | Register address: 0 code, 1 interrupt enable/status |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the collision in R9. The read of the status register has to land in exactly the cycle in which the vote decides to validate. That is two cycles after the edge that samples the last bit of the eighth matching message. The bench counts those cycles from the end of its message task and raises reg_rd exactly there. It then reads once more to show that the event survived the clear. A sweep over all 64 codes, with idle ones and corrupted messages mixed in, runs every hand-over from one validated code to the next. Each step is checked against a window model in the bench.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;
  localparam int CODE_W = 6;
  localparam int REG_W  = 8;
  localparam logic ADDR_CODE = 1'b0;
  localparam logic ADDR_INT  = 1'b1;
  // bit positions in the interrupt enable/status register
  localparam int VS_BIT = 0;
  localparam int VE_BIT = 1;
  localparam int RS_BIT = 2;
  localparam int RE_BIT = 3;
  localparam int VF_BIT = 4;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/feac_framer.sv
module feac_framer #(
  parameter int CODE_W = 6,
  parameter int TAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              frm_stb,
  output logic [CODE_W-1:0] frm_code
);
  localparam int MSG_W  = CODE_W + 2 + TAIL_W;
  localparam int STOP_B = CODE_W + 1;

  logic [MSG_W-1:0] sr_q;
  logic [MSG_W-1:0] sr_d;
  logic             hit;

  // newest bit enters at the top, so the oldest bit sits in position 0
  assign sr_d = {bit_in, sr_q[MSG_W-1:1]};

  always_comb begin
    hit = (sr_d[0] == 1'b0) && (sr_d[STOP_B] == 1'b0) && (&sr_d[MSG_W-1:STOP_B+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '1;
      frm_stb  <= 1'b0;
      frm_code <= '0;
    end else begin
      frm_stb <= 1'b0;
      if (bit_en) begin
        sr_q <= sr_d;
        if (hit) begin
          frm_stb  <= 1'b1;
          frm_code <= sr_d[CODE_W:1];
        end
      end
    end
  end
endmodule

// File: rtl/feac_vote.sv
module feac_vote #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 10,
  parameter int VAL_TH = 8,
  parameter int REM_TH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_stb,
  input  logic [CODE_W-1:0] in_code,
  output logic              val_evt,
  output logic              rem_evt,
  output logic              valid_q,
  output logic [CODE_W-1:0] code_q
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] hist_q [DEPTH];
  logic [DEPTH-1:0]  fill_q;
  logic              new_q;
  logic [DEPTH-1:0]  eq_new;
  logic [DEPTH-1:0]  ne_ref;
  logic [CNT_W-1:0]  n_match;
  logic [CNT_W-1:0]  n_diff;

  // history shift: data path without reset, occupancy tracked separately
  always_ff @(posedge clk) begin
    if (in_stb) begin
      hist_q[0] <= in_code;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      new_q  <= 1'b0;
    end else begin
      new_q <= in_stb;
      if (in_stb) fill_q <= {fill_q[DEPTH-2:0], 1'b1};
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq_new[g] = fill_q[g] && (hist_q[g] == hist_q[0]);
    assign ne_ref[g] = fill_q[g] && (hist_q[g] != code_q);
  end

  assign n_match = CNT_W'($countones(eq_new));
  assign n_diff  = CNT_W'($countones(ne_ref));

  assign val_evt = new_q && !valid_q && (n_match >= CNT_W'(VAL_TH));
  assign rem_evt = new_q &&  valid_q && (n_diff  >= CNT_W'(REM_TH));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else if (val_evt) begin
      valid_q <= 1'b1;
      code_q  <= hist_q[0];
    end else if (rem_evt) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/feac_regs.sv
module feac_regs
  import feac_rx_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic              addr,
  input  logic              wr_val_en,
  input  logic              wr_rem_en,
  input  logic              val_evt,
  input  logic              rem_evt,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic              val_st,
  output logic              rem_st,
  output logic              val_en,
  output logic              rem_en
);
  logic             rd_int;
  logic [REG_W-1:0] code_word;
  logic [REG_W-1:0] int_word;

  assign rd_int = rd && (addr == ADDR_INT);

  always_comb begin
    code_word = '0;
    code_word[CODE_W:1] = code;
    int_word = '0;
    int_word[VS_BIT] = val_st;
    int_word[VE_BIT] = val_en;
    int_word[RS_BIT] = rem_st;
    int_word[RE_BIT] = rem_en;
    int_word[VF_BIT] = valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_st <= 1'b0;
      rem_st <= 1'b0;
      val_en <= 1'b0;
      rem_en <= 1'b0;
      irq    <= 1'b0;
      rdata  <= '0;
    end else begin
      // an event in the cycle of a read wins over the clear
      if (val_evt)     val_st <= 1'b1;
      else if (rd_int) val_st <= 1'b0;
      if (rem_evt)     rem_st <= 1'b1;
      else if (rd_int) rem_st <= 1'b0;
      if (wr && (addr == ADDR_INT)) begin
        val_en <= wr_val_en;
        rem_en <= wr_rem_en;
      end
      irq <= (val_st && val_en) || (rem_st && rem_en);
      if (rd) rdata <= (addr == ADDR_INT) ? int_word : code_word;
    end
  end
endmodule

// File: rtl/feac_rx.sv
module feac_rx
  import feac_rx_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int VAL_TH = 8,
  parameter int REM_TH = 3,
  parameter int TAIL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fe_bit_en,
  input  logic             fe_bit,
  input  logic             reg_addr,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic  frm_stb;
  code_t frm_code;
  logic  val_evt;
  logic  rem_evt;
  logic  vld_flag;
  code_t code_reg;
  logic  val_st;
  logic  rem_st;
  logic  val_en;
  logic  rem_en;

  feac_framer #(.CODE_W(CODE_W), .TAIL_W(TAIL_W)) u_framer (
    .clk(clk), .rst(rst), .bit_en(fe_bit_en), .bit_in(fe_bit),
    .frm_stb(frm_stb), .frm_code(frm_code)
  );

  feac_vote #(.CODE_W(CODE_W), .DEPTH(DEPTH), .VAL_TH(VAL_TH), .REM_TH(REM_TH)) u_vote (
    .clk(clk), .rst(rst), .in_stb(frm_stb), .in_code(frm_code),
    .val_evt(val_evt), .rem_evt(rem_evt), .valid_q(vld_flag), .code_q(code_reg)
  );

  feac_regs #(.CODE_W(CODE_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .rd(reg_rd), .wr(reg_wr), .addr(reg_addr),
    .wr_val_en(reg_wdata[VE_BIT]), .wr_rem_en(reg_wdata[RE_BIT]),
    .val_evt(val_evt), .rem_evt(rem_evt), .valid(vld_flag), .code(code_reg),
    .rdata(reg_rdata), .irq(irq),
    .val_st(val_st), .rem_st(rem_st), .val_en(val_en), .rem_en(rem_en)
  );
endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_rd,
  input logic       reg_addr,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic       val_evt,
  input logic       rem_evt,
  input logic       valid,
  input logic       val_st,
  input logic       rem_st,
  input logic       val_en,
  input logic       rem_en
);
  // R2
  validate_sets_chk: assert property (@(posedge clk) disable iff (rst)
    val_evt |=> (valid && val_st));
  // R2
  validate_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    val_evt |-> !valid);
  // R4
  removal_sets_chk: assert property (@(posedge clk) disable iff (rst)
    rem_evt |=> (!valid && rem_st));
  // R4
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({val_evt, rem_evt}));
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr && !val_evt && !rem_evt) |=> (!val_st && !rem_st));
  // R8
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    ((val_st && val_en) || (rem_st && rem_en)) |=> irq);
  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !((val_st && val_en) || (rem_st && rem_en)) |=> !irq);
  // R11
  code_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_addr) |=> (!reg_rdata[7] && !reg_rdata[0]));
endmodule

bind feac_rx feac_rx_chk u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .val_evt(val_evt), .rem_evt(rem_evt),
  .valid(vld_flag), .val_st(val_st), .rem_st(rem_st),
  .val_en(val_en), .rem_en(rem_en)
);

// File: tb/sim_feac_rx.sv
module sim_feac_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fe_bit_en = 1'b0;
  logic       fe_bit = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference window model
  int mh [10];
  int mfill;
  bit mvalid, mvs, mrs, mve, mre;
  logic [5:0] mcode;

  always #5 clk = ~clk;

  feac_rx u0 (
    .clk(clk), .rst(rst), .fe_bit_en(fe_bit_en), .fe_bit(fe_bit),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [15:0] frame_of(input logic [5:0] c);
    return {8'hFF, 1'b0, c, 1'b0};
  endfunction

  task automatic model_reset();
    mfill = 0; mvalid = 0; mvs = 0; mrs = 0; mve = 0; mre = 0; mcode = 6'd0;
    for (int i = 0; i < 10; i++) mh[i] = 0;
  endtask

  task automatic model_frame(input int c);
    int cnt;
    for (int i = 9; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = c;
    if (mfill < 10) mfill++;
    cnt = 0;
    if (mvalid) begin
      for (int i = 0; i < mfill; i++) if (mh[i] != int'(mcode)) cnt++;
      if (cnt >= 3) begin mvalid = 0; mrs = 1; end
    end else begin
      for (int i = 0; i < mfill; i++) if (mh[i] == c) cnt++;
      if (cnt >= 8) begin mvalid = 1; mvs = 1; mcode = 6'(c); end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] f);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); fe_bit_en = 1'b1; fe_bit = f[i];
    end
    @(negedge clk); fe_bit_en = 1'b0;
  endtask

  task automatic idle_ones(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fe_bit_en = 1'b1; fe_bit = 1'b1;
    end
    @(negedge clk); fe_bit_en = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] int_exp();
    return {3'b000, mvalid, mre, mrs, mve, mvs};
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] d;
    repeat (4) @(negedge clk);
    check({tag, " R8 irq"}, {7'd0, irq}, {7'd0, (mvs & mve) | (mrs & mre)});
    reg_read(1'b1, d);
    check({tag, " int reg"}, d, int_exp());
    mvs = 0; mrs = 0;
    reg_read(1'b0, d);
    check({tag, " R11 code reg"}, d, {1'b0, mcode, 1'b0});
  endtask

  task automatic send_code(input logic [5:0] c, input string tag);
    send_bits(frame_of(c));
    model_frame(int'(c));
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check("R10 irq after reset", {7'd0, irq}, 8'h00);
    reg_read(1'b1, d); check("R10 int reg after reset", d, 8'h00);
    reg_read(1'b0, d); check("R10 code reg after reset", d, 8'h00);

    // R7: enables are read/write, status and valid bits ignore writes
    reg_write(1'b1, 8'hFF); mve = 1; mre = 1;
    reg_read(1'b1, d); check("R7 write ff", d, 8'h0A);
    reg_write(1'b1, 8'h02); mre = 0;
    reg_read(1'b1, d); check("R7 write 02", d, 8'h02);
    reg_write(1'b1, 8'h0A); mre = 1;

    // R3: seven matching messages do not validate
    for (int k = 0; k < 7; k++) send_code(6'h2D, "R3 below threshold");

    // R9: read lands in the cycle of the validation event
    send_bits(frame_of(6'h2D));
    @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
    check("R9 read data before event", reg_rdata, 8'h0A);
    model_frame(32'h2D);
    check_all("R2 R9 validated after colliding read");

    // R1: corrupted messages (last tail bit 0) are not counted
    for (int k = 0; k < 3; k++) begin
      send_bits(frame_of(6'h12) & 16'h7FFF);
      check_all("R1 corrupt message ignored");
    end
    idle_ones(12);
    check_all("R1 idle ones ignored");

    // R5 then R4 then R6
    send_code(6'h12, "R5 one differs");
    send_code(6'h12, "R5 two differ");
    send_code(6'h12, "R4 removal on three");
    for (int k = 0; k < 5; k++) send_code(6'h12, "R6 revalidation");

    // sweep over all codes with varied enables, idle bits and corruption
    for (int c = 0; c < 64; c++) begin
      reg_write(1'b1, {4'b0000, c[1], 1'b0, c[0], 1'b0});
      mve = c[0]; mre = c[1];
      for (int k = 0; k < 10; k++) begin
        if (c % 3 != 0) idle_ones(c % 3);
        if ((c % 8 == 5) && (k == 4)) send_bits(frame_of(6'(c)) ^ 16'h0001);
        send_code(6'(c), "R1/R2/R4/R6/R8 sweep");
      end
    end

    // R10: reset empties the window
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    reg_read(1'b1, d); check("R10 int reg after second reset", d, 8'h00);
    reg_read(1'b0, d); check("R10 code reg after second reset", d, 8'h00);
    for (int k = 0; k < 7; k++) send_code(6'h3F, "R10 window emptied");
    send_code(6'h3F, "R10 R2 validate after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule